// File: doc/BRIEF.md
# Serial Port FIFO and Interrupt Controller

This block sits between a serial shifter and the host side of a synchronous serial port. It holds two 8-entry, 16-bit queues. One carries words that the host writes toward the shifter. The other carries frames that the shifter has received toward the host. From the fill level of the two queues it derives the port status flags and four raw interrupt sources.

The raw sources are: transmit queue running low, receive queue filling up, received data left unread for too long, and a frame lost to a full receive queue. Each source has its own mask bit. The masked sources are ORed into a single interrupt line. The two sticky sources, timeout and overrun, are cleared by a write-one-to-clear strobe.

The shifter signals when it takes a word, when it delivers a frame, when it is mid-frame, and when each bit period elapses. The idle timer uses the bit-period ticks to measure how long received data has been left unread.

Top module: `serport_fifo_irq`

## Requirements
- R1: After reset, tx_empty_o and tx_not_full_o are 1; rx_not_empty_o, rx_full_o and busy_o are 0; raw_irq_o is 4'b1000; mask_o, mis_o and irq_o are 0.
- R2: Host writes reach tx_data_o in write order, one word per tx_pop_i. The queue holds 8 words. A write while tx_not_full_o is 0 is ignored and the word never appears.
- R3: host_rdata_o shows the oldest received frame, and host_rd_i removes it. While the receive queue is empty, host_rdata_o is 0 and a read changes nothing.
- R4: raw_irq_o[3] (transmit level) is 1 exactly when the transmit queue holds 4 or fewer words.
- R5: raw_irq_o[2] (receive level) is 1 exactly when the receive queue holds 4 or more frames.
- R6: raw_irq_o[1] (receive timeout) becomes 1 on the 32nd bit_tick_i that is counted while the receive queue is non-empty and no frame has arrived; it never sets while the queue is empty. It returns to 0 when the queue empties, when a frame arrives, or on a clear write with bit 1 set. A clear write also restarts the count.
- R7: A frame delivered while the receive queue is full sets raw_irq_o[0] (overrun). The queued frames are kept and the new frame is dropped. A set in the same cycle as a clear of bit 0 leaves the flag at 1.
- R8: A clear write affects only the bits written as 1; bits written as 0 and the level bits 3:2 are unchanged.
- R9: mask_wr_i loads mask_o from mask_wdata_i; mis_o equals raw_irq_o AND mask_o.
- R10: irq_o is 1 exactly when some bit of mis_o is 1.
- R11: busy_o is 1 when shift_busy_i is 1 or the transmit queue is not empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_wr_i | input | 1 | Host writes a word into the transmit queue |
| host_wdata_i | input | 16 | Word written by the host |
| host_rd_i | input | 1 | Host removes the oldest received frame |
| host_rdata_o | output | 16 | Oldest received frame, 0 when the queue is empty |
| tx_pop_i | input | 1 | Shifter takes the head word |
| tx_data_o | output | 16 | Head word of the transmit queue |
| rx_push_i | input | 1 | Shifter delivers a received frame |
| rx_data_i | input | 16 | Received frame |
| shift_busy_i | input | 1 | Shifter is inside a frame |
| bit_tick_i | input | 1 | One pulse per serial bit period |
| mask_wr_i | input | 1 | Load the interrupt mask |
| mask_wdata_i | input | 4 | New mask value |
| clr_wr_i | input | 1 | Write-one-to-clear strobe |
| clr_wdata_i | input | 4 | Clear bits (bit 1 timeout, bit 0 overrun) |
| tx_empty_o | output | 1 | Transmit queue empty |
| tx_not_full_o | output | 1 | Transmit queue has room |
| rx_not_empty_o | output | 1 | Receive queue holds data |
| rx_full_o | output | 1 | Receive queue full |
| busy_o | output | 1 | Port active |
| raw_irq_o | output | 4 | Raw sources: [3] tx level, [2] rx level, [1] timeout, [0] overrun |
| mask_o | output | 4 | Current mask |
| mis_o | output | 4 | Masked sources |
| irq_o | output | 1 | Combined interrupt |

## Verification
The sharpest collision is an overrun set and a clear of that same flag in one cycle. The bench provokes it by delivering a frame into a full receive queue while a write-one-to-clear of bit 0 is on the same cycle. It requires the flag to stay at 1 and the eight queued frames to read back unchanged. A second collision is a frame arriving on the cycle the idle count would expire. The bench judges this through the timeout bit: it must stay at 0 and restart its 32-tick count.

// File: rtl/sfic_pkg.sv
package sfic_pkg;
  localparam int IRQ_N    = 4;
  localparam int IRQ_ORUN = 0;
  localparam int IRQ_RTO  = 1;
  localparam int IRQ_RXL  = 2;
  localparam int IRQ_TXL  = 3;
endpackage

// File: rtl/sfic_fifo.sv
module sfic_fifo #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [CW-1:0]     count_o,
  output logic              full_o,
  output logic              empty_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [AW-1:0]     wr_ptr_q, rd_ptr_q;
  logic [CW-1:0]     count_q;
  logic              do_push, do_pop;

  assign full_o  = (count_q == CW'(DEPTH));
  assign empty_o = (count_q == '0);
  assign do_push = push_i & ~full_o;
  assign do_pop  = pop_i & ~empty_o;
  assign rdata_o = mem_q[rd_ptr_q];
  assign count_o = count_q;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (do_push) wr_ptr_q <= nxt(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= nxt(rd_ptr_q);
      case ({do_push, do_pop})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  // full queue refuses a lone push
  p_full_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i) |=> $stable(count_q));
  // empty queue ignores a lone pop
  p_empty_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && pop_i && !push_i) |=> (count_q == '0));
endmodule

// File: rtl/sfic_idle_timer.sv
module sfic_idle_timer #(
  parameter int LIMIT = 32,
  localparam int CW   = $clog2(LIMIT + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic armed_i,
  input  logic frame_i,
  input  logic tick_i,
  input  logic clr_i,
  output logic timeout_o
);
  logic [CW-1:0] cnt_q;
  logic          expired;

  assign expired   = (cnt_q == CW'(LIMIT));
  assign timeout_o = armed_i & expired;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (frame_i || !armed_i || clr_i) cnt_q <= '0;
    else if (tick_i && !expired)          cnt_q <= cnt_q + 1'b1;
  end

  p_frame_restart_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_i |=> !timeout_o);
  p_rise_on_tick_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_o) |-> $past(tick_i));
endmodule

// File: rtl/sfic_irq_ctrl.sv
module sfic_irq_ctrl
  import sfic_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tx_low_i,
  input  logic             rx_high_i,
  input  logic             rto_i,
  input  logic             ovr_set_i,
  input  logic             mask_wr_i,
  input  logic [IRQ_N-1:0] mask_wdata_i,
  input  logic             clr_wr_i,
  input  logic [IRQ_N-1:0] clr_wdata_i,
  output logic             rto_clr_o,
  output logic [IRQ_N-1:0] raw_o,
  output logic [IRQ_N-1:0] mask_o,
  output logic [IRQ_N-1:0] mis_o,
  output logic             irq_o
);
  logic             ovr_q;
  logic [IRQ_N-1:0] mask_q;

  assign rto_clr_o = clr_wr_i & clr_wdata_i[IRQ_RTO];

  always_comb begin
    raw_o           = '0;
    raw_o[IRQ_ORUN] = ovr_q;
    raw_o[IRQ_RTO]  = rto_i;
    raw_o[IRQ_RXL]  = rx_high_i;
    raw_o[IRQ_TXL]  = tx_low_i;
  end

  assign mask_o = mask_q;
  assign mis_o  = raw_o & mask_q;
  assign irq_o  = |mis_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovr_q  <= 1'b0;
      mask_q <= '0;
    end else begin
      if (ovr_set_i)                           ovr_q <= 1'b1; // set beats clear
      else if (clr_wr_i && clr_wdata_i[IRQ_ORUN]) ovr_q <= 1'b0;
      if (mask_wr_i) mask_q <= mask_wdata_i;
    end
  end

  p_ovr_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_set_i |=> raw_o[IRQ_ORUN]);
  p_clr_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_wr_i && !clr_wdata_i[IRQ_ORUN] && ovr_q) |=> ovr_q);
  p_mask_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mask_wr_i |=> $stable(mask_q));
endmodule

// File: rtl/serport_fifo_irq.sv
module serport_fifo_irq
  import sfic_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int DEPTH     = 8,
  parameter int TX_LOW    = 4,
  parameter int RX_HIGH   = 4,
  parameter int IDLE_BITS = 32,
  localparam int CW       = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_wr_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  input  logic              host_rd_i,
  output logic [DATA_W-1:0] host_rdata_o,
  input  logic              tx_pop_i,
  output logic [DATA_W-1:0] tx_data_o,
  input  logic              rx_push_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              shift_busy_i,
  input  logic              bit_tick_i,
  input  logic              mask_wr_i,
  input  logic [IRQ_N-1:0]  mask_wdata_i,
  input  logic              clr_wr_i,
  input  logic [IRQ_N-1:0]  clr_wdata_i,
  output logic              tx_empty_o,
  output logic              tx_not_full_o,
  output logic              rx_not_empty_o,
  output logic              rx_full_o,
  output logic              busy_o,
  output logic [IRQ_N-1:0]  raw_irq_o,
  output logic [IRQ_N-1:0]  mask_o,
  output logic [IRQ_N-1:0]  mis_o,
  output logic              irq_o
);
  logic [CW-1:0]     tx_cnt, rx_cnt;
  logic              tx_full, rx_empty;
  logic [DATA_W-1:0] rx_head;
  logic              rto, rto_clr;

  sfic_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_tx_fifo (
    .clk_i, .rst_ni,
    .push_i (host_wr_i),
    .wdata_i(host_wdata_i),
    .pop_i  (tx_pop_i),
    .rdata_o(tx_data_o),
    .count_o(tx_cnt),
    .full_o (tx_full),
    .empty_o(tx_empty_o)
  );

  sfic_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rx_fifo (
    .clk_i, .rst_ni,
    .push_i (rx_push_i),
    .wdata_i(rx_data_i),
    .pop_i  (host_rd_i),
    .rdata_o(rx_head),
    .count_o(rx_cnt),
    .full_o (rx_full_o),
    .empty_o(rx_empty)
  );

  assign tx_not_full_o  = ~tx_full;
  assign rx_not_empty_o = ~rx_empty;
  assign host_rdata_o   = rx_empty ? '0 : rx_head;
  assign busy_o         = shift_busy_i | ~tx_empty_o;

  sfic_idle_timer #(.LIMIT(IDLE_BITS)) u_idle (
    .clk_i, .rst_ni,
    .armed_i  (rx_not_empty_o),
    .frame_i  (rx_push_i),
    .tick_i   (bit_tick_i),
    .clr_i    (rto_clr),
    .timeout_o(rto)
  );

  sfic_irq_ctrl u_irq (
    .clk_i, .rst_ni,
    .tx_low_i    (tx_cnt <= CW'(TX_LOW)),
    .rx_high_i   (rx_cnt >= CW'(RX_HIGH)),
    .rto_i       (rto),
    .ovr_set_i   (rx_push_i & rx_full_o),
    .mask_wr_i,
    .mask_wdata_i,
    .clr_wr_i,
    .clr_wdata_i,
    .rto_clr_o   (rto_clr),
    .raw_o       (raw_irq_o),
    .mask_o,
    .mis_o,
    .irq_o
  );

  // overrun keeps the receive queue intact
  p_ovr_keep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_push_i && rx_full_o && !host_rd_i) |=> (rx_full_o && $stable(host_rdata_o)));
endmodule

// File: tb/sim_serport_fifo_irq.sv
module sim_serport_fifo_irq;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        host_wr = 0, host_rd = 0, tx_pop = 0, rx_push = 0;
  logic        shift_busy = 0, bit_tick = 0, mask_wr = 0, clr_wr = 0;
  logic [15:0] host_wdata = 0, rx_data = 0;
  logic [3:0]  mask_wdata = 0, clr_wdata = 0;
  logic [15:0] host_rdata, tx_data;
  logic        tx_empty, tx_nf, rx_ne, rx_full, busy, irq;
  logic [3:0]  raw, mask, mis;

  int n_chk = 0, n_fail = 0;
  int tx_n = 0, rx_n = 0;
  bit done = 0;
  logic [15:0] tx_q[$], rx_q[$];

  always #4 clk = ~clk;

  serport_fifo_irq u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .host_wr_i(host_wr), .host_wdata_i(host_wdata),
    .host_rd_i(host_rd), .host_rdata_o(host_rdata),
    .tx_pop_i(tx_pop), .tx_data_o(tx_data),
    .rx_push_i(rx_push), .rx_data_i(rx_data),
    .shift_busy_i(shift_busy), .bit_tick_i(bit_tick),
    .mask_wr_i(mask_wr), .mask_wdata_i(mask_wdata),
    .clr_wr_i(clr_wr), .clr_wdata_i(clr_wdata),
    .tx_empty_o(tx_empty), .tx_not_full_o(tx_nf),
    .rx_not_empty_o(rx_ne), .rx_full_o(rx_full), .busy_o(busy),
    .raw_irq_o(raw), .mask_o(mask), .mis_o(mis), .irq_o(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  // drivers: update the reference queues
  task automatic tx_write(input logic [15:0] d);
    host_wr = 1; host_wdata = d;
    if (tx_n < 8) begin tx_q.push_back(d); tx_n++; end
    step(); host_wr = 0;
  endtask

  task automatic tx_take();
    tx_pop = 1; step(); tx_pop = 0;
    if (tx_n > 0) tx_n--;
  endtask

  task automatic rx_frame(input logic [15:0] d, input logic [3:0] clr);
    rx_push = 1; rx_data = d; clr_wr = (clr != 0); clr_wdata = clr;
    if (rx_n < 8) begin rx_q.push_back(d); rx_n++; end
    step(); rx_push = 0; clr_wr = 0; clr_wdata = 0;
  endtask

  task automatic host_read();
    host_rd = 1; step(); host_rd = 0;
    if (rx_n > 0) rx_n--;
  endtask

  task automatic clear(input logic [3:0] c);
    clr_wr = 1; clr_wdata = c; step(); clr_wr = 0; clr_wdata = 0;
  endtask

  task automatic set_mask(input logic [3:0] m);
    mask_wr = 1; mask_wdata = m; step(); mask_wr = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin bit_tick = 1; step(); end
    bit_tick = 0;
  endtask

  // monitors: compare what the design hands out against the queues
  always @(negedge clk) begin
    if (rst_n && tx_pop && !tx_empty) begin
      if (tx_q.size() == 0) chk("R2 tx extra word", tx_data, 16'hxxxx);
      else chk("R2 tx order", tx_data, tx_q.pop_front());
    end
    if (rst_n && host_rd) begin
      if (rx_q.size() == 0) chk("R3 empty read", host_rdata, 0);
      else chk("R3 rx order", host_rdata, rx_q.pop_front());
    end
  end

  initial begin
    #(8 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    if (!done) $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    step(); step(); rst_n = 1; step();
    // R1
    chk("R1 tx_empty", tx_empty, 1); chk("R1 tx_not_full", tx_nf, 1);
    chk("R1 rx_not_empty", rx_ne, 0); chk("R1 rx_full", rx_full, 0);
    chk("R1 busy", busy, 0); chk("R1 raw", raw, 4'b1000);
    chk("R1 mask", mask, 0); chk("R1 mis", mis, 0); chk("R1 irq", irq, 0);

    // R11 shifter busy alone
    shift_busy = 1; #1; chk("R11 busy shifter", busy, 1); shift_busy = 0; #1;

    // R2 / R4 fill transmit queue
    for (int i = 0; i < 4; i++) tx_write(16'h1000 + 16'(i));
    chk("R4 four words low", raw[3], 1);
    chk("R11 busy queue", busy, 1);
    tx_write(16'h1004);
    chk("R4 five words", raw[3], 0);
    for (int i = 5; i < 8; i++) tx_write(16'h1000 + 16'(i));
    chk("R2 not_full at 8", tx_nf, 0);
    tx_write(16'hdead);
    chk("R2 still full", tx_nf, 0);
    for (int i = 0; i < 8; i++) tx_take();
    chk("R2 drained", tx_empty, 1);
    tx_take();
    chk("R2 pop empty", tx_empty, 1);
    chk("R4 empty low", raw[3], 1);

    // R3 read from empty
    host_read();
    chk("R3 still empty", rx_ne, 0);

    // R5 receive level
    for (int i = 0; i < 3; i++) rx_frame(16'h2000 + 16'(i), 0);
    chk("R5 three frames", raw[2], 0);
    rx_frame(16'h2003, 0);
    chk("R5 four frames", raw[2], 1);
    for (int i = 4; i < 8; i++) rx_frame(16'h2000 + 16'(i), 0);
    chk("R7 full", rx_full, 1);

    // R7 overrun, R8 clear semantics
    rx_frame(16'hbad0, 0);
    chk("R7 overrun set", raw[0], 1);
    clear(4'b1110);
    chk("R8 zero bit keeps overrun", raw[0], 1);
    chk("R8 level bits kept", raw[3:2], 2'b11);
    clear(4'b0001);
    chk("R7 overrun cleared", raw[0], 0);
    rx_frame(16'hbad1, 4'b0001);
    chk("R7 set wins over clear", raw[0], 1);

    // R9 / R10 masks: raw now 1101
    chk("R9 raw before mask", raw, 4'b1101);
    set_mask(4'b0001);
    chk("R9 mask load", mask, 4'b0001);
    chk("R9 mis", mis, 4'b0001); chk("R10 irq on", irq, 1);
    set_mask(4'b0010);
    chk("R9 mis timeout only", mis, 0); chk("R10 irq off", irq, 0);
    set_mask(4'b1100);
    chk("R9 mis levels", mis, 4'b1100); chk("R10 irq levels", irq, 1);
    set_mask(0);
    chk("R10 all masked", irq, 0);

    // drain receive queue; overrun frames must not appear
    for (int i = 0; i < 8; i++) host_read();
    chk("R3 drained", rx_ne, 0);
    clear(4'b0001);

    // R6 receive timeout
    ticks(40);
    chk("R6 empty no timeout", raw[1], 0);
    rx_frame(16'h3000, 0);
    ticks(31);
    chk("R6 31 ticks", raw[1], 0);
    ticks(1);
    chk("R6 32 ticks", raw[1], 1);
    clear(4'b0010);
    chk("R6 clear", raw[1], 0);
    ticks(31);
    rx_push = 1; rx_data = 16'h3001; bit_tick = 1; rx_q.push_back(16'h3001); rx_n++;
    step(); rx_push = 0; bit_tick = 0;
    chk("R6 frame on expiry tick", raw[1], 0);
    ticks(32);
    chk("R6 rearmed", raw[1], 1);
    rx_frame(16'h3002, 0);
    chk("R6 new frame clears", raw[1], 0);
    ticks(32);
    chk("R6 set again", raw[1], 1);
    host_read(); host_read();
    chk("R6 still pending", raw[1], 1);
    host_read();
    chk("R6 empty clears", raw[1], 0);
    chk("R3 final empty", rx_ne, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule